// File: doc/BRIEF.md
# Output Initialization Sequencer

This block produces the start-up quiet period for a serial audio output stage. An initialization window starts when the chip's power-on indication falls. It also starts when the active-low external reset pin returns high. The window lasts a fixed number of system clock cycles, 1024 by default. While it lasts, the block raises `init_busy` and drives its four serial outputs to fixed idle levels:

- the bit clock and both data lines are low;
- the word clock is high.

Once the window ends, the block passes the functional bit clock, word clock and data signals through to the outputs. Each signal is passed through one output register clocked by `sys_clk`.

The external pin is asynchronous, so it passes through a chain of synchronizer flops before it is used. While the pin is held low, the sequencer stays in its initialization state with the cycle count at zero. Counting starts only after the synchronized pin reads high. A reset arriving during a window that is already running starts the count again from zero. A reset arriving during normal running takes the block back into initialization.

Top module: `init_seq`

## Requirements
- R1: While `por` is high, `init_busy` is high and the outputs sit at their idle levels. When `por` falls, an initialization window runs without any activity on `ext_rst_n`.
- R2: `init_busy` falls on the rising edge numbered INIT_CYCLES + SYNC_STAGES after a release. That is edge 1026 with the defaults, and the first edge after the release is counted as 1. A release is `por` falling, or the pin rising, while the other reset source is inactive.
- R3: On every cycle in which `init_busy` is high, `bck_o`, `dl_o` and `dr_o` are 0, whatever the functional inputs are.
- R4: On every cycle in which `init_busy` is high, `wck_o` is 1, whatever `wck_i` is.
- R5: While the synchronized `ext_rst_n` is low, the sequencer stays in initialization with its count at zero. The window is timed from the pin's return to high.
- R6: If the external reset is asserted again during a running window, the count restarts from zero. The full window then runs again after the new release.
- R7: While the sequencer is running, each output equals the value its functional input had at the previous rising edge of `sys_clk`: `bck_o` from `bck_i`, `wck_o` from `wck_i`, `dl_o` from `dl_i`, `dr_o` from `dr_i`.
- R8: The outputs leave their idle levels on the same rising edge on which `init_busy` falls. On that edge they already carry the functional values.
- R9: A synchronized low on `ext_rst_n` during normal running, or on the edge that would end the window, puts the block in initialization. When both events fall on the same edge, the reset wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| por | input | 1 | Power-on reset indication, active high, synchronous to sys_clk |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| bck_i | input | 1 | Functional bit clock |
| wck_i | input | 1 | Functional word clock |
| dl_i | input | 1 | Functional left-channel data |
| dr_i | input | 1 | Functional right-channel data |
| init_busy | output | 1 | High during initialization |
| bck_o | output | 1 | Gated bit clock output |
| wck_o | output | 1 | Gated word clock output |
| dl_o | output | 1 | Gated left-channel data |
| dr_o | output | 1 | Gated right-channel data |

## Verification
Two events can fall on the same edge: the count reaching its terminal value, which would end the window, and a fresh external reset reaching the controller through the synchronizer. To provoke this, the bench drops the pin exactly SYNC_STAGES edges before the terminal edge. The bench then judges that `init_busy` is still high on that edge and that the outputs are still idle. After a new release, it expects a complete window of full length.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

  typedef enum logic {
    ST_INIT = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;

  // Lane order inside the gated output vector.
  localparam int LANE_DL  = 0;
  localparam int LANE_DR  = 1;
  localparam int LANE_BCK = 2;
  localparam int LANE_WCK = 3;
  localparam int N_LANES  = 4;

  // Idle level per lane during initialization: only the word clock is high.
  localparam logic [N_LANES-1:0] IDLE_LEVELS = 4'b1000;

endpackage

// File: rtl/init_seq_pin_sync.sv
module init_seq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic held_o
);

  logic [STAGES-1:0] chain_q;

  // Reset loads zeros: the pin is treated as asserted until a real high
  // value has travelled through the whole chain.
  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= (chain_q << 1) | STAGES'(pin_n);
  end

  assign held_o = ~chain_q[STAGES-1];

endmodule

// File: rtl/init_seq_ctrl.sv
module init_seq_ctrl
  import init_seq_pkg::*;
#(
  parameter int INIT_CYCLES = 1024,
  parameter int CNT_W       = $clog2(INIT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic busy_o,
  output logic busy_nxt_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES - 1);

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (hold_i) begin
      state_d = ST_INIT;
      cnt_d   = '0;
    end else if (state_q == ST_INIT) begin
      if (cnt_q == LAST) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_INIT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o     = (state_q == ST_INIT);
  assign busy_nxt_o = (state_d == ST_INIT);

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (busy_o && cnt_q == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !hold_i && cnt_q != LAST) |=>
      (busy_o && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R2
  terminal_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !hold_i && cnt_q == LAST) |=> !busy_o);

  // R9
  run_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !hold_i) |=> !busy_o);

endmodule

// File: rtl/init_seq_out_gate.sv
module init_seq_out_gate #(
  parameter int             N    = 4,
  parameter logic [N-1:0]   IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         force_i,
  input  logic         busy_i,
  input  logic [N-1:0] func_i,
  output logic [N-1:0] out_o
);

  logic [N-1:0] out_q;

  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || force_i) out_q[g] <= IDLE[g];
      else                out_q[g] <= func_i[g];
    end
  end

  assign out_o = out_q;

  // R3 R4
  idle_levels_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> (out_o == IDLE));

  // R7
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    !force_i |=> (out_o == $past(func_i)));

  // R8
  handover_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_i) |-> (out_o == $past(func_i)));

endmodule

// File: rtl/init_seq.sv
module init_seq
  import init_seq_pkg::*;
#(
  parameter int INIT_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic sys_clk,
  input  logic por,
  input  logic ext_rst_n,
  input  logic bck_i,
  input  logic wck_i,
  input  logic dl_i,
  input  logic dr_i,
  output logic init_busy,
  output logic bck_o,
  output logic wck_o,
  output logic dl_o,
  output logic dr_o
);

  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  logic               pin_held;
  logic               hold;
  logic               busy_nxt;
  logic [N_LANES-1:0] func_vec;
  logic [N_LANES-1:0] out_vec;

  init_seq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (sys_clk),
    .rst    (por),
    .pin_n  (ext_rst_n),
    .held_o (pin_held)
  );

  assign hold = por | pin_held;

  init_seq_ctrl #(.INIT_CYCLES(INIT_CYCLES), .CNT_W(CNT_W)) u_ctrl (
    .clk        (sys_clk),
    .rst        (por),
    .hold_i     (hold),
    .busy_o     (init_busy),
    .busy_nxt_o (busy_nxt)
  );

  always_comb begin
    func_vec           = '0;
    func_vec[LANE_DL]  = dl_i;
    func_vec[LANE_DR]  = dr_i;
    func_vec[LANE_BCK] = bck_i;
    func_vec[LANE_WCK] = wck_i;
  end

  init_seq_out_gate #(.N(N_LANES), .IDLE(IDLE_LEVELS)) u_gate (
    .clk     (sys_clk),
    .rst     (por),
    .force_i (busy_nxt),
    .busy_i  (init_busy),
    .func_i  (func_vec),
    .out_o   (out_vec)
  );

  assign dl_o  = out_vec[LANE_DL];
  assign dr_o  = out_vec[LANE_DR];
  assign bck_o = out_vec[LANE_BCK];
  assign wck_o = out_vec[LANE_WCK];

  // R1
  por_busy_chk: assert property (@(posedge sys_clk) por |=> init_busy);

endmodule

// File: tb/init_seq_tb_top.sv
module init_seq_tb_top;

  localparam int INIT_CYCLES = 1024;
  localparam int SYNC_STAGES = 2;
  localparam int WINDOW      = INIT_CYCLES + SYNC_STAGES;
  localparam logic [3:0] IDLE = 4'b1000;  // {wck,bck,dr,dl}

  logic sys_clk = 1'b0;
  logic por = 1'b1;
  logic ext_rst_n = 1'b1;
  logic bck_i = 1'b1, wck_i = 1'b0, dl_i = 1'b1, dr_i = 1'b1;
  logic init_busy, bck_o, wck_o, dl_o, dr_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 sys_clk = ~sys_clk;

  init_seq #(.INIT_CYCLES(INIT_CYCLES), .SYNC_STAGES(SYNC_STAGES)) dut_i (
    .sys_clk(sys_clk), .por(por), .ext_rst_n(ext_rst_n),
    .bck_i(bck_i), .wck_i(wck_i), .dl_i(dl_i), .dr_i(dr_i),
    .init_busy(init_busy), .bck_o(bck_o), .wck_o(wck_o),
    .dl_o(dl_o), .dr_o(dr_o)
  );

  function automatic logic [3:0] outv();
    return {wck_o, bck_o, dr_o, dl_o};
  endfunction

  function automatic logic [3:0] funcv();
    return {wck_i, bck_i, dr_i, dl_i};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    {wck_i, bck_i, dr_i, dl_i} = v;
  endtask

  // Called just after a release at a negedge. Counts rising edges until
  // init_busy falls; checks idle levels on every busy cycle and the
  // handover value on the falling edge.
  task automatic measure(input string req, output int n);
    int bad = 0;
    logic [3:0] last_func;
    n = 0;
    last_func = funcv();
    for (int i = 0; i < 3 * WINDOW; i++) begin
      @(posedge sys_clk); #1;
      n++;
      if (init_busy) begin
        if (outv() != IDLE) bad++;
      end else begin
        chk(outv() == last_func, "R8", "handover value", outv(), last_func);
        break;
      end
      @(negedge sys_clk);
      drive(4'($urandom));
      last_func = funcv();
    end
    chk(bad == 0, req, "idle levels R3 R4 during window", bad, 0);
  endtask

  task automatic t_reset_state();
    drive(4'b0111);
    repeat (4) @(posedge sys_clk);
    #1;
    chk(init_busy == 1'b1, "R1", "busy under por", init_busy, 1);
    chk(bck_o == 1'b0 && dl_o == 1'b0 && dr_o == 1'b0, "R3",
        "bck/data idle under por", outv(), IDLE);
    chk(wck_o == 1'b1, "R4", "wck idle under por", wck_o, 1);
  endtask

  task automatic t_por_window();
    int n;
    @(negedge sys_clk);
    por = 1'b0;
    measure("R1", n);
    chk(n == WINDOW, "R2", "por window length", n, WINDOW);
  endtask

  task automatic t_pass();
    for (int v = 0; v < 16; v++) begin
      @(negedge sys_clk);
      drive(4'(v));
      @(posedge sys_clk); #1;
      chk(outv() == 4'(v), "R7", "pass-through", outv(), v);
    end
    chk(init_busy == 1'b0, "R7", "busy stays low in run", init_busy, 0);
  endtask

  task automatic t_ext_reset();
    int n;
    int bad = 0;
    @(negedge sys_clk);
    ext_rst_n = 1'b0;
    drive(4'b0111);
    repeat (SYNC_STAGES + 1) @(posedge sys_clk);
    #1;
    chk(init_busy == 1'b1, "R9", "pin low reenters init", init_busy, 1);
    for (int i = 0; i < 20; i++) begin
      @(posedge sys_clk); #1;
      if (!init_busy || outv() != IDLE) bad++;
    end
    chk(bad == 0, "R5", "held while pin low", bad, 0);
    @(negedge sys_clk);
    ext_rst_n = 1'b1;
    measure("R5", n);
    chk(n == WINDOW, "R5", "window timed from pin release", n, WINDOW);
  endtask

  task automatic t_restart();
    int n;
    @(negedge sys_clk);
    ext_rst_n = 1'b0;
    repeat (4) @(negedge sys_clk);
    ext_rst_n = 1'b1;
    repeat (500) @(negedge sys_clk);
    ext_rst_n = 1'b0;
    repeat (3) @(negedge sys_clk);
    ext_rst_n = 1'b1;
    measure("R6", n);
    chk(n == WINDOW, "R6", "restart gives full window", n, WINDOW);
  endtask

  task automatic t_collide();
    int n;
    @(negedge sys_clk);
    ext_rst_n = 1'b0;
    repeat (4) @(negedge sys_clk);
    ext_rst_n = 1'b1;
    // Drop the pin just before edge WINDOW-SYNC_STAGES so that the
    // synchronized low meets the terminal edge WINDOW.
    repeat (WINDOW - SYNC_STAGES - 1) @(negedge sys_clk);
    ext_rst_n = 1'b0;
    drive(4'b0111);
    repeat (SYNC_STAGES + 1) @(posedge sys_clk);
    #1;
    chk(init_busy == 1'b1, "R9", "reset wins on terminal edge", init_busy, 1);
    chk(outv() == IDLE, "R9", "outputs idle on terminal edge", outv(), IDLE);
    repeat (5) @(negedge sys_clk);
    ext_rst_n = 1'b1;
    measure("R6", n);
    chk(n == WINDOW, "R2", "window after collision", n, WINDOW);
  endtask

  initial begin
    #(200000 * 4);
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_por_window();
    t_pass();
    t_ext_reset();
    t_pass();
    t_restart();
    t_collide();
    t_pass();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule